// File: doc/BRIEF.md
# Two-Channel Sequential Debug Break Unit

This block watches a stream of pre-decoded bus accesses with two comparison channels. Each channel checks the access address under a per-bit ignore mask. It can also check the data value under a second mask, and it filters on access direction and on which bus the access came from (instruction or operand). When a channel's condition holds, it sets a sticky flag. A channel with its break enable set raises a break request. The request leaves the block as a one-cycle pulse at the next instruction boundary that is not a delayed branch or its delay slot, so a break never lands inside a branch pair.

The two channels can be chained in either order. The later channel carries the chain setting and names the earlier one. It raises the request only if the earlier channel's flag is already set when it matches. The earlier channel keeps its matched state until software clears its flag. Channel 1 also has a down-counter. With counting enabled, channel 1 counts as matched only on the hit that takes the counter to zero.

Configuration and flag clearing use a simple write port with a combinational read-back. Register offsets: channel c uses offsets 5c+0 (address), 5c+1 (address mask), 5c+2 (data), 5c+3 (data mask) and 5c+4 (control). Offset 10 is the execution counter and offset 11 holds the flags (bit c for channel c). Control bits: 0 enable, 1 match reads, 2 match writes, 3 operand bus (0 selects instruction bus), 4 data compare, 5 chain enable, 6 earlier-channel number, 7 break enable, 8 count enable (channel 1 only).

Top module: `dbg_seq_break`

## Requirements
- R1: Each configuration register reads back the value last written on reg_rdata_o, zero-extended. Control registers keep bits 8:0, and channel 0's control bit 8 always reads 0.
- R2: A channel matches when every address bit whose mask bit is 0 equals the programmed address. A mask bit of 1 ignores that bit. A match sets the channel's flag in register 11.
- R3: A channel matches a read only if control bit 1 is set and a write only if control bit 2 is set. acc_operand_i must equal control bit 3.
- R4: With control bit 4 set, data bits whose data-mask bit is 0 must equal the programmed data. An access with acc_nodata_i high never satisfies a data compare.
- R5: Writing 1 to bit c of register 11 clears flag c. A match of channel c in the same cycle wins, and the flag stays set.
- R6: Chain 0 then 1 (channel 1 control bits 5 set, bit 6 = 0): channel 1 raises a break only when it matches while flag 0 is set. A lone channel 1 match sets flag 1 and raises nothing.
- R7: Chain 1 then 0 (channel 0 control bits 5 set, bit 6 = 1): channel 0 raises a break only when it matches while flag 1 is set.
- R8: A flag stays set until it is cleared. Clearing the earlier channel's flag releases the chain, so a later match of the second channel raises no break.
- R9: A raised request is held and issued after the first edge with retire_i high and branch_slot_i low. Boundaries with branch_slot_i high do not issue it.
- R10: brk_o is a one-cycle pulse. A match on a channel whose break enable (control bit 7) is clear never produces one.
- R11: The 12-bit counter at offset 10 loads on write. With channel 1 control bit 8 set, it decrements on every channel 1 address hit, and channel 1 matches only on the hit made while it holds 1 (or 0).
- R12: After reset all registers, flags and brk_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register offset for write and read |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Read data for reg_addr_i |
| acc_valid_i | input | 1 | An access is observed this cycle |
| acc_addr_i | input | AW | Access address |
| acc_data_i | input | DW | Access data value |
| acc_write_i | input | 1 | 1 for write, 0 for read |
| acc_operand_i | input | 1 | 1 for operand bus, 0 for instruction bus |
| acc_nodata_i | input | 1 | Access carries no data (prefetch or cache maintenance) |
| retire_i | input | 1 | An instruction boundary occurs this cycle |
| branch_slot_i | input | 1 | That boundary belongs to a delayed branch or its slot |
| brk_o | output | 1 | Break request pulse |

## Verification
The bench uses the default widths: 32-bit address and data and a 12-bit counter. At these widths, the full-width mask and data patterns are exercised. Writing 0x1ABC to the counter shows the truncation to 12 bits. A load of 3 reaches zero within three hits, so the count condition is checked in a few cycles. Both chain orders, the released chain, the data-less access and deferral across two slot boundaries are all reachable with these values.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  localparam int unsigned NCH         = 2;
  localparam int unsigned RA_W        = 4;
  localparam int unsigned REGS_PER_CH = 5;
  localparam int unsigned CNT_CH      = 1;
  localparam int unsigned K_ADDR      = 0;
  localparam int unsigned K_AMSK      = 1;
  localparam int unsigned K_DATA      = 2;
  localparam int unsigned K_DMSK      = 3;
  localparam int unsigned K_CTRL      = 4;
  localparam logic [RA_W-1:0] RG_ECNT = 4'd10;
  localparam logic [RA_W-1:0] RG_FLAG = 4'd11;

  typedef struct packed {
    logic cnt_en;     // 8
    logic brk_en;     // 7
    logic first_sel;  // 6
    logic seq_en;     // 5
    logic dcmp_en;    // 4
    logic operand;    // 3
    logic wr_en;      // 2
    logic rd_en;      // 1
    logic en;         // 0
  } ch_ctrl_t;

  localparam int unsigned CTRL_W = $bits(ch_ctrl_t);

  function automatic logic [RA_W-1:0] reg_off(int unsigned ch, int unsigned k);
    return RA_W'(ch * REGS_PER_CH + k);
  endfunction
endpackage

// File: rtl/dsb_match.sv
module dsb_match #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          en_i,
  input  logic          rd_en_i,
  input  logic          wr_en_i,
  input  logic          operand_i,
  input  logic          dcmp_en_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [AW-1:0] cfg_amsk_i,
  input  logic [DW-1:0] cfg_data_i,
  input  logic [DW-1:0] cfg_dmsk_i,
  input  logic          acc_valid_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [DW-1:0] acc_data_i,
  input  logic          acc_write_i,
  input  logic          acc_operand_i,
  input  logic          acc_nodata_i,
  output logic          hit_o
);
  logic addr_ok, data_ok, dir_ok, bus_ok;

  always_comb begin
    addr_ok = ((acc_addr_i ^ cfg_addr_i) & ~cfg_amsk_i) == '0;
    // data-less accesses can never satisfy a data compare
    data_ok = !dcmp_en_i ||
              (!acc_nodata_i && (((acc_data_i ^ cfg_data_i) & ~cfg_dmsk_i) == '0));
    dir_ok  = acc_write_i ? wr_en_i : rd_en_i;
    bus_ok  = (acc_operand_i == operand_i);
    hit_o   = en_i & acc_valid_i & addr_ok & data_ok & dir_ok & bus_ok;
  end
endmodule

// File: rtl/dsb_exec_cnt.sv
module dsb_exec_cnt #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             use_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             met_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 cnt_q <= '0;
    else if (ld_i)                               cnt_q <= ld_val_i;
    else if (use_i && hit_i && (cnt_q != '0))    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o = cnt_q;
  assign met_o = hit_i && (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/dsb_regs.sv
module dsb_regs
  import dsb_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [RA_W-1:0]           addr_i,
  input  logic [DW-1:0]             wdata_i,
  input  logic [NCH-1:0]            ev_i,
  input  logic [CNT_W-1:0]          cnt_i,
  output logic [NCH-1:0][AW-1:0]    addr_o,
  output logic [NCH-1:0][AW-1:0]    amsk_o,
  output logic [NCH-1:0][DW-1:0]    data_o,
  output logic [NCH-1:0][DW-1:0]    dmsk_o,
  output ch_ctrl_t [NCH-1:0]        ctrl_o,
  output logic [NCH-1:0]            flag_o,
  output logic                      cnt_ld_o,
  output logic [DW-1:0]             rdata_o
);
  logic [NCH-1:0] flag_q, clr;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ch_ctrl_t wctrl;
    always_comb begin
      wctrl = ch_ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (c != CNT_CH) wctrl.cnt_en = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_o[c] <= '0;
        amsk_o[c] <= '0;
        data_o[c] <= '0;
        dmsk_o[c] <= '0;
        ctrl_o[c] <= '0;
      end else if (we_i) begin
        if (addr_i == reg_off(c, K_ADDR)) addr_o[c] <= wdata_i[AW-1:0];
        if (addr_i == reg_off(c, K_AMSK)) amsk_o[c] <= wdata_i[AW-1:0];
        if (addr_i == reg_off(c, K_DATA)) data_o[c] <= wdata_i;
        if (addr_i == reg_off(c, K_DMSK)) dmsk_o[c] <= wdata_i;
        if (addr_i == reg_off(c, K_CTRL)) ctrl_o[c] <= wctrl;
      end
    end
  end

  assign clr = (we_i && addr_i == RG_FLAG) ? wdata_i[NCH-1:0] : '0;

  // a new match beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= ev_i | (flag_q & ~clr);
  end

  assign flag_o   = flag_q;
  assign cnt_ld_o = we_i && (addr_i == RG_ECNT);

  always_comb begin
    rdata_o = '0;
    for (int unsigned c = 0; c < NCH; c++) begin
      if (addr_i == reg_off(c, K_ADDR)) rdata_o = DW'(addr_o[c]);
      if (addr_i == reg_off(c, K_AMSK)) rdata_o = DW'(amsk_o[c]);
      if (addr_i == reg_off(c, K_DATA)) rdata_o = data_o[c];
      if (addr_i == reg_off(c, K_DMSK)) rdata_o = dmsk_o[c];
      if (addr_i == reg_off(c, K_CTRL)) rdata_o = DW'(ctrl_o[c]);
    end
    if (addr_i == RG_ECNT) rdata_o = DW'(cnt_i);
    if (addr_i == RG_FLAG) rdata_o = DW'(flag_q);
  end
endmodule

// File: rtl/dsb_break_seq.sv
module dsb_break_seq
  import dsb_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] ev_i,
  input  logic [NCH-1:0] flag_i,
  input  logic [NCH-1:0] seq_en_i,
  input  logic [NCH-1:0] first_sel_i,
  input  logic [NCH-1:0] brk_en_i,
  input  logic           retire_i,
  input  logic           slot_i,
  output logic           brk_o
);
  logic [NCH-1:0] trig;
  logic pend_q, brk_q, fire;

  // chained channel needs the earlier channel's registered flag
  for (genvar c = 0; c < NCH; c++) begin : g_trig
    assign trig[c] = ev_i[c] & brk_en_i[c] & (~seq_en_i[c] | flag_i[first_sel_i[c]]);
  end

  assign fire = pend_q & retire_i & ~slot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~fire) | (|trig);
      brk_q  <= fire;
    end
  end

  assign brk_o = brk_q;
endmodule

// File: rtl/dbg_seq_break.sv
module dbg_seq_break
  import dsb_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [3:0]      reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  input  logic            acc_valid_i,
  input  logic [AW-1:0]   acc_addr_i,
  input  logic [DW-1:0]   acc_data_i,
  input  logic            acc_write_i,
  input  logic            acc_operand_i,
  input  logic            acc_nodata_i,
  input  logic            retire_i,
  input  logic            branch_slot_i,
  output logic            brk_o
);
  logic [NCH-1:0][AW-1:0] cfg_addr, cfg_amsk;
  logic [NCH-1:0][DW-1:0] cfg_data, cfg_dmsk;
  ch_ctrl_t [NCH-1:0]     ctrl;
  logic [NCH-1:0]         flag_q, hit, ev, met, dcmp_en;
  logic [NCH-1:0]         seq_en, first_sel, brk_en;
  logic [CNT_W-1:0]       cnt;
  logic                   cnt_ld;

  dsb_regs #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .ev_i    (ev),
    .cnt_i   (cnt),
    .addr_o  (cfg_addr),
    .amsk_o  (cfg_amsk),
    .data_o  (cfg_data),
    .dmsk_o  (cfg_dmsk),
    .ctrl_o  (ctrl),
    .flag_o  (flag_q),
    .cnt_ld_o(cnt_ld),
    .rdata_o (reg_rdata_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign dcmp_en[c]   = ctrl[c].dcmp_en;
    assign seq_en[c]    = ctrl[c].seq_en;
    assign first_sel[c] = ctrl[c].first_sel;
    assign brk_en[c]    = ctrl[c].brk_en;

    dsb_match #(.AW(AW), .DW(DW)) u_match (
      .en_i         (ctrl[c].en),
      .rd_en_i      (ctrl[c].rd_en),
      .wr_en_i      (ctrl[c].wr_en),
      .operand_i    (ctrl[c].operand),
      .dcmp_en_i    (dcmp_en[c]),
      .cfg_addr_i   (cfg_addr[c]),
      .cfg_amsk_i   (cfg_amsk[c]),
      .cfg_data_i   (cfg_data[c]),
      .cfg_dmsk_i   (cfg_dmsk[c]),
      .acc_valid_i  (acc_valid_i),
      .acc_addr_i   (acc_addr_i),
      .acc_data_i   (acc_data_i),
      .acc_write_i  (acc_write_i),
      .acc_operand_i(acc_operand_i),
      .acc_nodata_i (acc_nodata_i),
      .hit_o        (hit[c])
    );

    if (c == CNT_CH) begin : g_cnt
      dsb_exec_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ld_i    (cnt_ld),
        .ld_val_i(reg_wdata_i[CNT_W-1:0]),
        .use_i   (ctrl[c].cnt_en),
        .hit_i   (hit[c]),
        .cnt_o   (cnt),
        .met_o   (met[c])
      );
    end else begin : g_nocnt
      assign met[c] = 1'b0;  // cnt_en is held at 0 on this channel
    end

    assign ev[c] = hit[c] & (~ctrl[c].cnt_en | met[c]);
  end

  dsb_break_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (ev),
    .flag_i     (flag_q),
    .seq_en_i   (seq_en),
    .first_sel_i(first_sel),
    .brk_en_i   (brk_en),
    .retire_i   (retire_i),
    .slot_i     (branch_slot_i),
    .brk_o      (brk_o)
  );
endmodule

// File: rtl/dbg_seq_break_chk.sv
module dbg_seq_break_chk
  import dsb_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           reg_we_i,
  input logic [3:0]     reg_addr_i,
  input logic [NCH-1:0] clr_bits_i,
  input logic           acc_valid_i,
  input logic           acc_nodata_i,
  input logic [NCH-1:0] dcmp_en_i,
  input logic [NCH-1:0] ev_i,
  input logic [NCH-1:0] flag_i,
  input logic           retire_i,
  input logic           branch_slot_i,
  input logic           brk_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_c
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_i[c] && !(reg_we_i && reg_addr_i == RG_FLAG && clr_bits_i[c])) |=> flag_i[c]); // R8
    AST_MATCH_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_i[c] |=> flag_i[c]); // R5
    AST_NODATA_NO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_valid_i && acc_nodata_i && dcmp_en_i[c] && !flag_i[c]) |=> !flag_i[c]); // R4
  end

  AST_BRK_AT_PLAIN_RETIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> $past(retire_i && !branch_slot_i)); // R9
endmodule

bind dbg_seq_break dbg_seq_break_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .clr_bits_i   (reg_wdata_i[1:0]),
  .acc_valid_i  (acc_valid_i),
  .acc_nodata_i (acc_nodata_i),
  .dcmp_en_i    (dcmp_en),
  .ev_i         (ev),
  .flag_i       (flag_q),
  .retire_i     (retire_i),
  .branch_slot_i(branch_slot_i),
  .brk_o        (brk_o)
);

// File: tb/dbg_seq_break_tb_top.sv
module dbg_seq_break_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYC     = 20000;
  localparam logic [31:0] C_EN = 32'h001, C_RD = 32'h002, C_WR = 32'h004, C_OP = 32'h008,
                          C_DC = 32'h010, C_SEQ = 32'h020, C_FS = 32'h040, C_BRK = 32'h080,
                          C_CNT = 32'h100;
  localparam logic [31:0] A0 = 32'h0000_1000, A1 = 32'h0000_2000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_operand = 1'b0, acc_nodata = 1'b0;
  logic [31:0] acc_addr = '0, acc_data = '0;
  logic        retire = 1'b0, slot = 1'b0, brk;

  int n_chk = 0, n_bad = 0;

  dbg_seq_break dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .acc_valid_i(acc_valid),
    .acc_addr_i(acc_addr), .acc_data_i(acc_data), .acc_write_i(acc_write),
    .acc_operand_i(acc_operand), .acc_nodata_i(acc_nodata), .retire_i(retire),
    .branch_slot_i(slot), .brk_o(brk)
  );

  typedef struct packed {logic [3:0] a; logic [31:0] d; logic [31:0] e;} vec_t;
  localparam int N_VEC = 8;
  localparam vec_t VEC [N_VEC] = '{
    '{4'd0,  32'h1234_5678, 32'h1234_5678},
    '{4'd1,  32'h0000_00F0, 32'h0000_00F0},
    '{4'd2,  32'hDEAD_BEEF, 32'hDEAD_BEEF},
    '{4'd3,  32'h0000_FFFF, 32'h0000_FFFF},
    '{4'd4,  32'hFFFF_FFFF, 32'h0000_00FF},
    '{4'd5,  32'h8000_0004, 32'h8000_0004},
    '{4'd9,  32'hFFFF_FFFF, 32'h0000_01FF},
    '{4'd10, 32'h0000_1ABC, 32'h0000_0ABC}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic flags(logic [1:0] exp, string tag);
    logic [31:0] v;
    rd(4'd11, v); chk(tag, v, {30'd0, exp});
  endtask

  task automatic acc(logic [31:0] a, logic [31:0] d, logic w, logic op, logic nd);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_data = d; acc_write = w; acc_operand = op; acc_nodata = nd;
    @(negedge clk); acc_valid = 1'b0; acc_nodata = 1'b0;
  endtask

  task automatic ret(logic s, logic exp, string tag);
    @(negedge clk); retire = 1'b1; slot = s;
    @(negedge clk); chk(tag, {31'd0, brk}, {31'd0, exp}); retire = 1'b0; slot = 1'b0;
  endtask

  task automatic setup(int ch, logic [31:0] a, logic [31:0] am, logic [31:0] d,
                       logic [31:0] dm, logic [31:0] ctl);
    wr(4'(ch*5+0), a); wr(4'(ch*5+1), am); wr(4'(ch*5+2), d);
    wr(4'(ch*5+3), dm); wr(4'(ch*5+4), ctl);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    flags(2'b00, "R12 flags");
    rd(4'd10, v); chk("R12 counter", v, 32'd0);
    rd(4'd4, v);  chk("R12 ctrl0", v, 32'd0);
    chk("R12 brk", {31'd0, brk}, 32'd0);

    // R1 / R11 register table
    for (int i = 0; i < N_VEC; i++) wr(VEC[i].a, VEC[i].d);
    for (int i = 0; i < N_VEC; i++) begin
      rd(VEC[i].a, v);
      chk((VEC[i].a == 4'd10) ? "R11 load width" : "R1 readback", v, VEC[i].e);
    end

    // R2 masked address match, R10 pulse
    setup(0, A0, 32'h0000_000F, 0, 0, C_EN|C_RD|C_WR|C_OP|C_BRK);
    setup(1, A1, 0, 0, 0, 0);
    wr(4'd11, 3);
    acc(A0 | 32'h8, 0, 1'b0, 1'b1, 1'b0);
    flags(2'b01, "R2 masked bit ignored");
    ret(1'b0, 1'b1, "R10 break issued");
    @(negedge clk); chk("R10 single pulse", {31'd0, brk}, 32'd0);
    wr(4'd11, 3);
    acc(A0 | 32'h10, 0, 1'b0, 1'b1, 1'b0);
    flags(2'b00, "R2 unmasked bit differs");

    // R3 direction and bus qualification
    setup(0, A0, 0, 0, 0, C_EN|C_WR|C_OP);
    acc(A0, 0, 1'b0, 1'b1, 1'b0);
    flags(2'b00, "R3 read rejected");
    acc(A0, 0, 1'b1, 1'b0, 1'b0);
    flags(2'b00, "R3 instruction bus rejected");
    acc(A0, 0, 1'b1, 1'b1, 1'b0);
    flags(2'b01, "R3 operand write accepted");
    ret(1'b0, 1'b0, "R10 no break without enable");

    // R4 data compare
    setup(0, A0, 0, 32'hCAFE_0000, 32'h0000_FFFF, C_EN|C_RD|C_OP|C_DC);
    wr(4'd11, 3);
    acc(A0, 32'hCAFE_0000, 1'b0, 1'b1, 1'b1);
    flags(2'b00, "R4 data-less access");
    acc(A0, 32'hCAFF_0000, 1'b0, 1'b1, 1'b0);
    flags(2'b00, "R4 data mismatch");
    acc(A0, 32'hCAFE_1234, 1'b0, 1'b1, 1'b0);
    flags(2'b01, "R4 masked data match");

    // R5 clear, and clear colliding with a match
    wr(4'd11, 1);
    flags(2'b00, "R5 write-1 clear");
    acc(A0, 32'hCAFE_0000, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd11; reg_wdata = 32'd1;
    acc_valid = 1'b1; acc_addr = A0; acc_data = 32'hCAFE_0000; acc_write = 1'b0; acc_operand = 1'b1;
    @(negedge clk); reg_we = 1'b0; acc_valid = 1'b0;
    flags(2'b01, "R5 match wins over clear");

    // R6 chain 0 then 1
    setup(0, A0, 0, 0, 0, C_EN|C_RD|C_OP);
    setup(1, A1, 0, 0, 0, C_EN|C_RD|C_OP|C_SEQ|C_BRK);
    wr(4'd11, 3);
    acc(A1, 0, 1'b0, 1'b1, 1'b0);
    flags(2'b10, "R6 lone second sets flag");
    ret(1'b0, 1'b0, "R6 lone second no break");
    wr(4'd11, 3);
    acc(A0, 0, 1'b0, 1'b1, 1'b0);
    ret(1'b0, 1'b0, "R10 first channel silent");
    acc(A1, 0, 1'b0, 1'b1, 1'b0);
    flags(2'b11, "R6 both flags");
    ret(1'b0, 1'b1, "R6 chain break");

    // R7 chain 1 then 0
    setup(1, A1, 0, 0, 0, C_EN|C_RD|C_OP);
    setup(0, A0, 0, 0, 0, C_EN|C_RD|C_OP|C_SEQ|C_FS|C_BRK);
    wr(4'd11, 3);
    acc(A0, 0, 1'b0, 1'b1, 1'b0);
    ret(1'b0, 1'b0, "R7 lone second no break");
    acc(A1, 0, 1'b0, 1'b1, 1'b0);
    acc(A0, 0, 1'b0, 1'b1, 1'b0);
    ret(1'b0, 1'b1, "R7 chain break");

    // R8 stuck first channel and release
    wr(4'd11, 3);
    acc(A1, 0, 1'b0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    flags(2'b10, "R8 flag held");
    wr(4'd11, 2);
    flags(2'b00, "R8 released");
    acc(A0, 0, 1'b0, 1'b1, 1'b0);
    ret(1'b0, 1'b0, "R8 no break after release");

    // R9 deferral across delay slot boundaries
    setup(0, A0, 0, 0, 0, C_EN|C_RD|C_OP|C_BRK);
    setup(1, A1, 0, 0, 0, 0);
    acc(A0, 0, 1'b0, 1'b1, 1'b0);
    ret(1'b1, 1'b0, "R9 held at branch");
    ret(1'b1, 1'b0, "R9 held at slot");
    ret(1'b0, 1'b1, "R9 issued at target");

    // R11 execution count
    setup(0, A0, 0, 0, 0, 0);
    setup(1, A1, 0, 0, 0, C_EN|C_RD|C_OP|C_BRK|C_CNT);
    wr(4'd10, 3);
    wr(4'd11, 3);
    acc(A1, 0, 1'b0, 1'b1, 1'b0);
    flags(2'b00, "R11 first hit no match");
    rd(4'd10, v); chk("R11 decrement", v, 32'd2);
    acc(A1, 0, 1'b0, 1'b1, 1'b0);
    flags(2'b00, "R11 second hit no match");
    acc(A1, 0, 1'b0, 1'b1, 1'b0);
    flags(2'b10, "R11 count reached");
    rd(4'd10, v); chk("R11 counter zero", v, 32'd0);
    ret(1'b0, 1'b1, "R11 count break");

    summary();
    $finish;
  end
endmodule